// File: doc/BRIEF.md
# Pseudo-Random Density Fade Modulator

This block drives a group of output pins with a one-bit stream whose density of ones moves slowly from one level to the other. It is meant to release or engage an analog mute stage gently. The dither comes from a linear congruential generator, not from a counter. As a result, the residue after an external RC filter is broadband noise rather than a fixed PWM tone.

The block has a 15-bit ratio. In every busy cycle, the generator yields a fresh 15-bit sample. The sample is added to the ratio, and the carry out of that addition sets the selected pins. After a fixed batch of such cycles, the ratio moves by the programmed speed. It moves upward for a rising fade and downward for a falling one. When the next move would leave the 15-bit range, the fade stops. The selected pins then settle at the destination level, and the ready output returns high.

Only the pins named by a mask are modulated. The other bits of the output word are frozen at the values of the input word when the fade was launched.

Top module: `prf_fade_mod`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `word_out` to all zeros and sets `ready` high, including in the middle of a fade.
- R2: A `start` pulse sampled while `ready` is high launches a fade. From the next cycle, `ready` is low. The masked bits of `word_out` show the starting level: 0 when `fade_down` is 0 and 1 when `fade_down` is 1.
- R3: Each launch loads the 32-bit generator state with 0x0000FFFF. In each busy cycle the state becomes (16217·x + 9043) mod 2^32, and the dither sample is bits [30:16] of the new state.
- R4: In a busy cycle that is not the last one, the masked bits of `word_out` are all 1 when the sample plus the ratio is at least 0x8000, and all 0 otherwise.
- R5: The ratio starts at 0 for a rising fade and at 0x7FFF for a falling fade. It holds for BATCH busy cycles, then moves by `speed` (added when rising, subtracted when falling).
- R6: At the end of a batch, the fade ends if the moved ratio would exceed 0x7FFF (rising) or fall below 0 (falling). In that cycle, `ready` goes high and the masked bits settle at 1 (rising) or 0 (falling). A fade therefore lasts (floor(0x7FFF/speed)+1)·BATCH cycles.
- R7: Bits outside the mask captured at launch keep the value `word_in` had at launch. Changes to `word_in` and `pin_mask` during a fade have no effect on `word_out`.
- R8: A `start` pulse while `ready` is low is ignored. The running fade continues unchanged in output sequence and length.
- R9: While `ready` is high and `start` is low, `word_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch pulse, honoured only while ready |
| fade_down | input | 1 | 0: fade from low to high, 1: fade from high to low |
| speed | input | STEP_W | Ratio increment per batch, must be nonzero |
| pin_mask | input | PIN_W | Bits of the output word to modulate |
| word_in | input | PIN_W | Current output word, unmasked bits are kept |
| word_out | output | PIN_W | Updated output word |
| ready | output | 1 | Low while a fade is running |

## Verification
The assertions assume that `speed` is nonzero at launch. With a speed of zero the ratio never moves, so the fade would never end and the end-of-fade property could never be reached.

The properties also assume that `start` is the only way a fade begins. Mask and direction may change freely at the pins during a fade, because the checker observes the values captured at launch.

The stimulus always launches with a nonzero speed. During every fade it scrambles `word_in` and `pin_mask` and pulses `start`, so the captured values are exercised without breaking any assumption.

// File: rtl/prf_pkg.sv
package prf_pkg;

    // Fade direction held for the duration of one fade.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } fade_dir_e;

endpackage

// File: rtl/prf_lcg.sv
// One step of the linear congruential generator plus extraction of the
// dither sample from the new state.
module prf_lcg #(
    parameter int              LCG_W   = 32,
    parameter int              OUT_W   = 15,
    parameter logic [LCG_W-1:0] LCG_MUL = 16217,
    parameter logic [LCG_W-1:0] LCG_INC = 9043
) (
    input  logic [LCG_W-1:0] state_cur,
    output logic [LCG_W-1:0] state_nxt,
    output logic [OUT_W-1:0] sample
);
    // Sample window ends one bit below the top of the state.
    localparam int TOP = LCG_W - 2;

    always_comb begin
        state_nxt = state_cur * LCG_MUL + LCG_INC;
        sample    = state_nxt[TOP -: OUT_W];
    end
endmodule

// File: rtl/prf_dither.sv
// Carry out of sample + ratio, computed as a compare against the
// complement so no unused sum bits remain.
module prf_dither #(
    parameter int RATIO_W = 15
) (
    input  logic [RATIO_W-1:0] sample,
    input  logic [RATIO_W-1:0] ratio,
    output logic               hit
);
    always_comb begin
        hit = (sample > ~ratio);
    end
endmodule

// File: rtl/prf_ratio.sv
// Ratio stepper: proposes the next ratio and flags when the move
// would leave the representable range.
module prf_ratio #(
    parameter int RATIO_W = 15,
    parameter int STEP_W  = 16
) (
    input  logic               down,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [STEP_W-1:0]  step,
    output logic [RATIO_W-1:0] ratio_nxt,
    output logic               out_of_range
);
    localparam int EXT_W = ((RATIO_W > STEP_W) ? RATIO_W : STEP_W) + 1;

    logic [EXT_W-1:0] up_sum;
    logic [EXT_W-1:0] dn_dif;

    always_comb begin
        up_sum = EXT_W'(ratio) + EXT_W'(step);
        dn_dif = EXT_W'(ratio) - EXT_W'(step);
        if (down) begin
            ratio_nxt    = dn_dif[RATIO_W-1:0];
            // A borrow fills every bit above the ratio field.
            out_of_range = |dn_dif[EXT_W-1:RATIO_W];
        end else begin
            ratio_nxt    = up_sum[RATIO_W-1:0];
            out_of_range = |up_sum[EXT_W-1:RATIO_W];
        end
    end
endmodule

// File: rtl/prf_pinmix.sv
// Per-pin selection between the frozen word and the modulated level.
module prf_pinmix #(
    parameter int PIN_W = 8
) (
    input  logic [PIN_W-1:0] keep,
    input  logic [PIN_W-1:0] mask,
    input  logic             level,
    output logic [PIN_W-1:0] word
);
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        assign word[i] = mask[i] ? level : keep[i];
    end
endmodule

// File: rtl/prf_fade_mod.sv
module prf_fade_mod
    import prf_pkg::*;
#(
    parameter int               PIN_W    = 8,
    parameter int               RATIO_W  = 15,
    parameter int               STEP_W   = 16,
    parameter int               BATCH    = 16383,
    parameter int               LCG_W    = 32,
    parameter logic [LCG_W-1:0] LCG_MUL  = 16217,
    parameter logic [LCG_W-1:0] LCG_INC  = 9043,
    parameter logic [LCG_W-1:0] LCG_SEED = 32'h0000_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fade_down,
    input  logic [STEP_W-1:0] speed,
    input  logic [PIN_W-1:0]  pin_mask,
    input  logic [PIN_W-1:0]  word_in,
    output logic [PIN_W-1:0]  word_out,
    output logic              ready
);
    localparam int               CNT_W     = (BATCH > 1) ? $clog2(BATCH) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(BATCH - 1);
    localparam logic [RATIO_W-1:0] RATIO_TOP = {RATIO_W{1'b1}};

    typedef struct packed {
        logic               busy;
        fade_dir_e          dir;
        logic [LCG_W-1:0]   lcg;
        logic [RATIO_W-1:0] ratio;
        logic [STEP_W-1:0]  step;
        logic [CNT_W-1:0]   cnt;
        logic [PIN_W-1:0]   mask;
        logic [PIN_W-1:0]   keep;
        logic [PIN_W-1:0]   word;
    } fade_state_t;

    fade_state_t st_d, st_q;

    logic [LCG_W-1:0]   lcg_nxt_d;
    logic [RATIO_W-1:0] sample_d;
    logic               hit_d;
    logic [RATIO_W-1:0] ratio_nxt_d;
    logic               ratio_end_d;
    logic               batch_end_d;
    logic               dir_is_down_d;
    logic [PIN_W-1:0]   word_dither_d;
    logic [PIN_W-1:0]   word_final_d;
    logic [PIN_W-1:0]   word_launch_d;
    logic [PIN_W-1:0]   keep_launch_d;

    // Views of held state for the bound checker.
    logic [PIN_W-1:0]   mask_held;
    logic               dir_held;
    logic [RATIO_W-1:0] ratio_held;

    assign dir_is_down_d = (st_q.dir == DIR_DOWN);
    assign batch_end_d   = (st_q.cnt == CNT_LAST);
    assign keep_launch_d = word_in & ~pin_mask;

    prf_lcg #(
        .LCG_W  (LCG_W),
        .OUT_W  (RATIO_W),
        .LCG_MUL(LCG_MUL),
        .LCG_INC(LCG_INC)
    ) u_lcg (
        .state_cur(st_q.lcg),
        .state_nxt(lcg_nxt_d),
        .sample   (sample_d)
    );

    prf_dither #(
        .RATIO_W(RATIO_W)
    ) u_dither (
        .sample(sample_d),
        .ratio (st_q.ratio),
        .hit   (hit_d)
    );

    prf_ratio #(
        .RATIO_W(RATIO_W),
        .STEP_W (STEP_W)
    ) u_ratio (
        .down        (dir_is_down_d),
        .ratio       (st_q.ratio),
        .step        (st_q.step),
        .ratio_nxt   (ratio_nxt_d),
        .out_of_range(ratio_end_d)
    );

    // Word during a dither cycle.
    prf_pinmix #(.PIN_W(PIN_W)) u_mix_dither (
        .keep (st_q.keep),
        .mask (st_q.mask),
        .level(hit_d),
        .word (word_dither_d)
    );

    // Word once the fade has reached its destination.
    prf_pinmix #(.PIN_W(PIN_W)) u_mix_final (
        .keep (st_q.keep),
        .mask (st_q.mask),
        .level(!dir_is_down_d),
        .word (word_final_d)
    );

    // Word at launch: masked pins sit at the starting level.
    prf_pinmix #(.PIN_W(PIN_W)) u_mix_launch (
        .keep (keep_launch_d),
        .mask (pin_mask),
        .level(fade_down),
        .word (word_launch_d)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.lcg  = lcg_nxt_d;
            st_d.word = word_dither_d;
            if (batch_end_d) begin
                st_d.cnt = '0;
                if (ratio_end_d) begin
                    st_d.busy = 1'b0;
                    st_d.word = word_final_d;
                end else begin
                    st_d.ratio = ratio_nxt_d;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (start) begin
            st_d.busy  = 1'b1;
            st_d.dir   = fade_down ? DIR_DOWN : DIR_UP;
            st_d.lcg   = LCG_SEED;
            st_d.ratio = fade_down ? RATIO_TOP : '0;
            st_d.step  = speed;
            st_d.cnt   = '0;
            st_d.mask  = pin_mask;
            st_d.keep  = keep_launch_d;
            st_d.word  = word_launch_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_out   = st_q.word;
    assign ready      = !st_q.busy;
    assign mask_held  = st_q.mask;
    assign dir_held   = dir_is_down_d;
    assign ratio_held = st_q.ratio;

endmodule

// File: rtl/prf_fade_chk.sv
module prf_fade_chk #(
    parameter int PIN_W   = 8,
    parameter int RATIO_W = 15
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               ready,
    input logic [PIN_W-1:0]   word_out,
    input logic [PIN_W-1:0]   mask_held,
    input logic               dir_held,
    input logic [RATIO_W-1:0] ratio_held
);
    // R1: the cycle after reset shows the cleared state
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ready && (word_out == '0)));

    // R2: an accepted launch drops ready
    a_r2_launch_busy: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> !ready);

    // R5: the ratio only moves in the fade direction
    a_r5_ratio_dir: assert property (@(posedge clk) disable iff (rst)
        (!ready && !$past(ready) && !$past(rst)) |->
            (dir_held ? (ratio_held <= $past(ratio_held))
                      : (ratio_held >= $past(ratio_held))));

    // R6: the masked pins settle at the destination level
    a_r6_final_level: assert property (@(posedge clk) disable iff (rst)
        (ready && !$past(ready) && !$past(rst)) |->
            ((word_out & mask_held) == (dir_held ? '0 : mask_held)));

    // R7: unmasked bits do not move during a fade
    a_r7_keep_stable: assert property (@(posedge clk) disable iff (rst)
        !ready |=> ((word_out & ~mask_held) == $past(word_out & ~mask_held)));

    // R8: a start while busy leaves the captured setup alone
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (!ready && start) |=> ($stable(mask_held) && $stable(dir_held)));

    // R9: idle without start keeps the word
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> $stable(word_out));
endmodule

bind prf_fade_mod prf_fade_chk #(
    .PIN_W  (PIN_W),
    .RATIO_W(RATIO_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ready     (ready),
    .word_out  (word_out),
    .mask_held (mask_held),
    .dir_held  (dir_held),
    .ratio_held(ratio_held)
);

// File: tb/tb_prf_fade_mod.sv
module tb_prf_fade_mod;
    localparam int PIN_W  = 4;
    localparam int STEP_W = 16;
    localparam int BATCH  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              fade_down = 1'b0;
    logic [STEP_W-1:0] speed = '0;
    logic [PIN_W-1:0]  pin_mask = '0;
    logic [PIN_W-1:0]  word_in = '0;
    logic [PIN_W-1:0]  word_out;
    logic              ready;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 20 ns period

    prf_fade_mod #(
        .PIN_W (PIN_W),
        .STEP_W(STEP_W),
        .BATCH (BATCH)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .fade_down(fade_down),
        .speed    (speed),
        .pin_mask (pin_mask),
        .word_in  (word_in),
        .word_out (word_out),
        .ready    (ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Runs one full fade and compares every cycle against the model.
    task automatic run_fade(input bit dn, input int spd, input logic [PIN_W-1:0] m,
                            input logic [PIN_W-1:0] w);
        logic [31:0]      x;
        int               ratio;
        int               cnt;
        int               nr;
        int               cycles;
        bit               done;
        bit               hi;
        logic [PIN_W-1:0] keep;
        logic [PIN_W-1:0] exp_w;

        fade_down = dn;
        speed     = STEP_W'(spd);
        pin_mask  = m;
        word_in   = w;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        keep  = w & ~m;
        // R2: launch level and ready low
        chk("R2 ready", int'(ready), 0);
        chk("R2 launch word", int'(word_out), int'(keep | (dn ? m : '0)));

        x      = 32'h0000_FFFF;      // R3 seed
        ratio  = dn ? 32767 : 0;     // R5 start ratio
        cnt    = 0;
        cycles = 0;
        done   = 1'b0;
        while (!done) begin
            // R7 / R8: scramble inputs and poke start during the fade
            word_in  = ~word_in;
            pin_mask = PIN_W'(cycles + 5);
            fade_down = ~fade_down;
            start    = (cycles == 2);

            x  = x * 32'd16217 + 32'd9043;              // R3
            hi = (int'(x[30:16]) + ratio) >= 32768;     // R4
            if (cnt == BATCH - 1) begin
                cnt = 0;
                nr  = dn ? ratio - spd : ratio + spd;   // R5
                if (dn ? (nr < 0) : (nr > 32767)) done = 1'b1;  // R6
                else ratio = nr;
            end else begin
                cnt++;
            end
            exp_w = done ? (keep | (dn ? '0 : m)) : (keep | (hi ? m : '0));
            @(negedge clk);
            cycles++;
            chk(done ? "R6 final word" : "R4 R7 dither word", int'(word_out), int'(exp_w));
            chk("R6 R8 ready", int'(ready), int'(done));
        end
        start = 1'b0;
        // R6: length of the fade
        chk("R6 length", cycles, (32767 / spd + 1) * BATCH);
        // R9: idle hold
        for (int i = 0; i < 2; i++) begin
            word_in = ~word_in;
            @(negedge clk);
            chk("R9 idle hold", int'(word_out), int'(exp_w));
        end
    endtask

    initial begin
        int spds[3] = '{32'h2000, 32'h7FFF, 32'h1555};
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset word", int'(word_out), 0);
        chk("R1 reset ready", int'(ready), 1);

        for (int d = 0; d < 2; d++)
            for (int m = 1; m < 16; m++)
                for (int s = 0; s < 3; s++)
                    run_fade(d[0], spds[s], PIN_W'(m), PIN_W'(m ^ 10));

        run_fade(1'b0, 32'h0100, 4'hF, 4'h0);
        run_fade(1'b1, 32'h0100, 4'h6, 4'h9);

        // R1: reset in the middle of a fade
        fade_down = 1'b1;
        speed     = 16'h0100;
        pin_mask  = 4'hF;
        word_in   = 4'h0;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-fade word", int'(word_out), 0);
        chk("R1 mid-fade ready", int'(ready), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule